// File: doc/BRIEF.md
# Expansion Slot Reset Sequencer

This block drives the active-low reset line of the downstream expansion slots. The line is pulled low by three causes. The first is the system reset input: while it is low the slot reset is low, and after it is released the slot reset stays low for a fixed interval that covers the time the on-chip clock synthesizers need to lock. The second is a software reset bit in a bridge options register, which holds the slot reset low for as long as it is set. The third is a software write to the clock synthesizer tuning field: when the write changes the field's value, the same timed interval starts again.

The timed interval is a parameter, `HOLD_CYC`, counted in cycles of the reference clock `clk`. The default is 16667 cycles, which gives about 500 us at 33.33 MHz. The slot reset is the OR of the timed hold and the software bit, and it comes straight from a flop.

Software reaches both fields through one plain write port that has no handshake. When `wr_en` is high at a rising edge, the write is taken in that cycle. `wr_sel` picks the target: 0 selects the options register and 1 selects the tuning register. The release of `sys_rst_n` must be synchronous to `clk`. Its assertion may be asynchronous.

Top module: `slot_rst_seq`

## Requirements
- R1: While `sys_rst_n` is low, `slot_rst_n` is low, the software reset bit is cleared and the hold counter sits at zero.
- R2: After `sys_rst_n` is released with the software bit clear, `slot_rst_n` stays low through the first `HOLD_CYC` rising edges and goes high at rising edge `HOLD_CYC`+1.
- R3: An options write (`wr_sel`=0) with `wr_data[12]`=1 drives `slot_rst_n` low from the rising edge after the write edge. An options write with `wr_data[12]`=0 and no hold running releases it from that same edge.
- R4: `slot_rst_n` is low whenever the hold is running or the software bit is set. A bit set during a hold keeps the reset low after the hold ends, until the bit is cleared. Clearing the bit during a hold does not shorten the hold.
- R5: A tuning write (`wr_sel`=1) whose field `wr_data[3:0]` differs from the stored field drives `slot_rst_n` low from the next rising edge. The reset then goes high at rising edge `HOLD_CYC`+1 counted from the write edge.
- R6: The following writes have no effect on `slot_rst_n`: a tuning write whose field equals the stored value (whatever the other data bits are), and an options write with `wr_data[12]`=0 while the bit is already clear.
- R7: A field-changing tuning write that arrives while a hold is running restarts the hold from zero. The reset goes high `HOLD_CYC`+1 edges after the latest change.
- R8: A software bit set before `sys_rst_n` is asserted is cleared by that reset. After release, the output goes high when the timed hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the hold counter |
| sys_rst_n | input | 1 | System reset, active low, asynchronous assert |
| wr_en | input | 1 | Register write strobe, taken at the rising edge |
| wr_sel | input | 1 | Write target: 0 options register, 1 tuning register |
| wr_data | input | DATA_W | Write data; bit 12 is the software reset, bits [3:0] the tuning field |
| slot_rst_n | output | 1 | Slot reset, active low, driven from a flop |

## Verification
Every result lags its cause by a fixed number of edges. A software bit write shows on `slot_rst_n` one edge after the write edge. A tuning change pulls the output low one edge after the write edge and releases it `HOLD_CYC`+1 edges after that edge. The system reset release behaves like a write at edge zero, so it follows the same count. The bench numbers the edges after each event and samples at every falling edge in between, comparing against the expected low/high level at each count. This catches a hold that ends one cycle early or late, not only a wrong final level.

// File: rtl/slot_rst_pkg.sv
package slot_rst_pkg;
  typedef enum logic {
    SEL_OPTIONS = 1'b0,
    SEL_TUNING  = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/slot_rst_ctl.sv
module slot_rst_ctl
  import slot_rst_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SWRST_BIT = 12,
  parameter int TUNE_W    = 4,
  parameter int TUNE_LSB  = 0,
  parameter logic [TUNE_W-1:0] TUNE_INIT = '0
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  wr_sel_e           wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sw_rst_q,
  output logic              retrig
);
  logic [TUNE_W-1:0] tune_q;
  logic [TUNE_W-1:0] tune_new;
  logic              opt_wr;
  logic              tune_wr;
  logic              unused_data;

  assign tune_new    = wr_data[TUNE_LSB +: TUNE_W];
  assign opt_wr      = wr_en && (wr_sel == SEL_OPTIONS);
  assign tune_wr     = wr_en && (wr_sel == SEL_TUNING);
  assign retrig      = tune_wr && (tune_new != tune_q);
  assign unused_data = ^wr_data;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      sw_rst_q <= 1'b0;
      tune_q   <= TUNE_INIT;
    end else begin
      if (opt_wr) sw_rst_q <= wr_data[SWRST_BIT];
      if (retrig) tune_q   <= tune_new;
    end
  end
endmodule

// File: rtl/slot_rst_timer.sv
module slot_rst_timer #(
  parameter int HOLD_CYC = 16667
) (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic retrig,
  output logic hold_on
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hold_q;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (retrig) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (hold_q) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        hold_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_on = hold_q;
endmodule

// File: rtl/slot_rst_seq.sv
module slot_rst_seq
  import slot_rst_pkg::*;
#(
  parameter int HOLD_CYC  = 16667,
  parameter int DATA_W    = 32,
  parameter int SWRST_BIT = 12,
  parameter int TUNE_W    = 4,
  parameter int TUNE_LSB  = 0,
  parameter logic [TUNE_W-1:0] TUNE_INIT = '0
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              slot_rst_n
);
  logic sw_rst_q;
  logic retrig;
  logic hold_on;
  logic rst_n_q;

  slot_rst_ctl #(
    .DATA_W(DATA_W), .SWRST_BIT(SWRST_BIT), .TUNE_W(TUNE_W),
    .TUNE_LSB(TUNE_LSB), .TUNE_INIT(TUNE_INIT)
  ) u_ctl (
    .clk(clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .wr_sel(wr_sel_e'(wr_sel)), .wr_data(wr_data),
    .sw_rst_q(sw_rst_q), .retrig(retrig)
  );

  slot_rst_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk(clk), .sys_rst_n(sys_rst_n), .retrig(retrig), .hold_on(hold_on)
  );

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) rst_n_q <= 1'b0;
    else            rst_n_q <= ~(hold_on | sw_rst_q);
  end

  assign slot_rst_n = rst_n_q;
endmodule

// File: rtl/slot_rst_seq_chk.sv
module slot_rst_seq_chk #(
  parameter int HOLD_CYC  = 16667,
  parameter int DATA_W    = 32,
  parameter int SWRST_BIT = 12,
  parameter int TUNE_W    = 4,
  parameter int TUNE_LSB  = 0,
  parameter logic [TUNE_W-1:0] TUNE_INIT = '0,
  parameter int CNT_W     = 1
) (
  input logic              clk,
  input logic              sys_rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              slot_rst_n,
  input logic [CNT_W-1:0]  cnt
);
  localparam int SW = $clog2(HOLD_CYC + 2) + 1;
  localparam logic [SW-1:0] DONE = SW'(HOLD_CYC + 1);

  logic [TUNE_W-1:0] shadow_tune;
  logic              shadow_sw;
  logic [SW-1:0]     since;
  logic              chg;
  logic              sw_set_wr;

  assign chg       = wr_en && wr_sel && (wr_data[TUNE_LSB +: TUNE_W] != shadow_tune);
  assign sw_set_wr = wr_en && !wr_sel && wr_data[SWRST_BIT];

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      shadow_tune <= TUNE_INIT;
      shadow_sw   <= 1'b0;
      since       <= '0;
    end else begin
      if (wr_en && !wr_sel) shadow_sw <= wr_data[SWRST_BIT];
      if (chg) begin
        shadow_tune <= wr_data[TUNE_LSB +: TUNE_W];
        since       <= '0;
      end else if (since != DONE) begin
        since <= since + 1'b1;
      end
    end
  end

  // R1
  p_low_in_reset_r1: assert property (@(posedge clk)
    !sys_rst_n |-> (!slot_rst_n && cnt == '0));

  p_no_early_rise_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(slot_rst_n) |-> (since == DONE));

  p_release_after_hold_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (since == DONE && !shadow_sw && !$past(shadow_sw)) |-> slot_rst_n);

  p_sw_forces_low_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    sw_set_wr |=> ##1 !slot_rst_n);

  p_sw_held_low_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (shadow_sw && $past(shadow_sw)) |-> !slot_rst_n);

  p_retune_low_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    chg |=> ##1 !slot_rst_n);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    int'(cnt) < HOLD_CYC);
endmodule

bind slot_rst_seq slot_rst_seq_chk #(
  .HOLD_CYC(HOLD_CYC), .DATA_W(DATA_W), .SWRST_BIT(SWRST_BIT),
  .TUNE_W(TUNE_W), .TUNE_LSB(TUNE_LSB), .TUNE_INIT(TUNE_INIT),
  .CNT_W((HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1)
) u_chk (
  .clk(clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .slot_rst_n(slot_rst_n), .cnt(u_timer.cnt_q)
);

// File: tb/slot_rst_seq_tb.sv
`timescale 1ns/1ps
module slot_rst_seq_tb;
  localparam int HOLD = 20;
  localparam int DW   = 32;
  localparam int NEVER = 100000;

  logic          clk = 1'b0;
  logic          sys_rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          slot_rst_n;
  int            n_run = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  slot_rst_seq #(.HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .slot_rst_n(slot_rst_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: slot_rst_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drives one write; returns just after the edge that takes it.
  task automatic do_write(input logic sel, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // Checks after each of n edges following an event edge; output is
  // expected high from edge count rise_k on. An optional write is
  // driven after edge wk and taken at edge wk+1.
  task automatic window(input string tag, input int n, input int rise_k,
                        input int wk, input logic sel, input logic [DW-1:0] d);
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      #1 wr_en = 1'b0;
      @(negedge clk);
      chk(tag, slot_rst_n, (k >= rise_k) ? 1'b1 : 1'b0);
      if (k == wk) begin
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
      end
    end
  endtask

  task automatic por(input string tag, input int rcyc);
    @(negedge clk);
    sys_rst_n = 1'b0;
    for (int i = 0; i < rcyc; i++) begin
      @(negedge clk);
      chk("R1 low during reset", slot_rst_n, 1'b0);
    end
    sys_rst_n = 1'b1;
    window(tag, HOLD + 3, HOLD + 1, 0, 1'b0, '0);
  endtask

  initial begin
    #1;
    chk("R1 reset state", slot_rst_n, 1'b0);
    // R2 power-on sweep over several reset lengths
    for (int r = 1; r <= 4; r++) por("R2 power-on hold", r);

    // R3 software assert and release with no hold running
    do_write(1'b0, 32'h0000_1000);
    @(negedge clk);
    chk("R3 one edge of latency", slot_rst_n, 1'b1);
    window("R3 sw bit set", 4, NEVER, 0, 1'b0, '0);
    do_write(1'b0, 32'h0000_0000);
    window("R3 sw bit clear", 3, 1, 0, 1'b0, '0);

    // R6 ignored writes
    do_write(1'b1, 32'hFFFF_FFF0);
    window("R6 same tuning field", HOLD + 3, 0, 0, 1'b0, '0);
    do_write(1'b0, 32'hFFFF_EFFF);
    window("R6 options write bit12=0", 4, 0, 0, 1'b0, '0);

    // R5 every field value change retriggers the full hold
    for (int v = 1; v <= 16; v++) begin
      do_write(1'b1, 32'(v % 16) | 32'hA5A5_0000);
      window("R5 retune hold", HOLD + 3, HOLD + 1, 0, 1'b0, '0);
    end

    // R7 change during a hold restarts it at the later write
    for (int w = 2; w <= HOLD - 2; w += 6) begin
      do_write(1'b1, 32'h0000_0003);
      window("R7 restart hold", w + HOLD + 4, w + 1 + HOLD + 1, w, 1'b1, 32'h0000_0005);
      do_write(1'b1, 32'h0000_0000);
      window("R7 settle", HOLD + 2, HOLD + 1, 0, 1'b0, '0);
    end

    // R4 bit set during hold outlives it; then clear releases
    do_write(1'b1, 32'h0000_0009);
    window("R4 sw set in hold", HOLD + 6, NEVER, 3, 1'b0, 32'h0000_1000);
    do_write(1'b0, 32'h0000_0000);
    window("R4 sw cleared", 3, 1, 0, 1'b0, '0);
    // R4 clear during hold does not shorten it
    do_write(1'b0, 32'h0000_1000);
    do_write(1'b1, 32'h0000_000C);
    window("R4 clear in hold", HOLD + 3, HOLD + 1, 4, 1'b0, 32'h0000_0000);

    // R8 system reset clears the software bit
    do_write(1'b0, 32'h0000_1000);
    window("R8 sw set before reset", 3, NEVER, 0, 1'b0, '0);
    por("R8 bit cleared by reset", 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule